// File: doc/BRIEF.md
# Streaming Pixel Doubler

The block widens one packed scan line horizontally by a factor of two. Once started, it fetches 32-bit words from a source line buffer through a read port with one cycle of latency. For every fetched word it emits two 32-bit words to a destination buffer, in which each pixel of the source stands twice side by side. The same datapath serves pixel depths of 1, 2, 4, 8, 16 and 32 bits. Each narrow depth has its own construction: byte-lane replication, a nibble merge under a fixed mask, a split into even and odd bit planes that are later woven back together, and a plain bit spread.

A controller raises `start` with a depth code and a source word count. The block then runs through the line on its own: one read every other cycle and one write every cycle, at destination addresses that climb from zero. It signals completion with a single-cycle `done`. The default sizing covers a 320-pixel line at any depth, which upscales to 640 pixels.

Top module: `pixel_doubler`

## Requirements
- R1: While reset is held and after it is released, `rd_en`, `wr_en` and `done` are low until a start is accepted.
- R2: A run of N source words reads addresses 0 to N-1 in ascending order and writes addresses 0 to 2N-1 in ascending order. Source word k goes to address 2k as its doubled low 16 bits (bits 15:0) and then to address 2k+1 in the next cycle as its doubled high 16 bits (bits 31:16).
- R3: Depth code 3 (8 bpp) writes source bytes 1,1,0,0 (most to least significant lane) first, then bytes 3,3,2,2.
- R4: Depth code 4 (16 bpp) writes the low halfword twice, then the high halfword twice.
- R5: Depth code 2 (4 bpp) repeats every nibble of a half in place, so that halfword 0xABCD becomes 0xAABBCCDD.
- R6: Depth code 1 (2 bpp) repeats every 2-bit pixel of a half, so that halfword 0x00E4 becomes 0x0000FA50.
- R7: Depth code 0 (1 bpp) copies source bit i into output bits 2i and 2i+1. Bits 0 to 15 land in the first word and bits 16 to 31 in the second.
- R8: Depth code 5 (32 bpp) writes each source word unchanged twice. Codes 6 and 7 behave as code 5.
- R9: With start sampled in cycle s, the first read is in cycle s+1, reads never occur in two consecutive cycles, the last write is in cycle s+2+2N, and `done` is high for exactly the cycle s+3+2N.
- R10: A start that arrives while a run is in progress, including its done cycle, is ignored. The depth code and word count are sampled only when a start is accepted.
- R11: A start with a word count of zero causes no read and no write, and `done` pulses in the cycle after the start.
- R12: A full 320-pixel line at 8 bpp (80 words) yields 160 writes, and `done` comes 163 cycles after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; ignored while busy |
| depth | input | 3 | Pixel depth code, 0..5 for 1..32 bpp |
| src_words | input | 9 | Number of source words in the line |
| rd_en | output | 1 | Source read strobe |
| rd_addr | output | 9 | Source word address |
| rd_data | input | 32 | Source word, valid the cycle after `rd_en` |
| wr_en | output | 1 | Destination write strobe |
| wr_addr | output | 10 | Destination word address |
| wr_data | output | 32 | Doubled pixel word |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench targets the depth-specific shuffles with pixel values that expose swapped lanes. A design that mixed up the halves or the lane order would write 0x78785656 where 0x56567878 belongs, and a wrong nibble mask would smear neighbouring nibbles. It also probes the 2 bpp weave, where reversed planes turn each pixel 1 into a 2, and the spare depth codes, which a sloppy decode would route to a narrow shuffle. On the control side it counts reads, writes and done pulses across an empty line, a full 80-word line and a second start injected mid-run. A design that restarted, dropped the final high word or pulsed done early would show a wrong count or a shifted done cycle.

// File: rtl/pd_pkg.sv
package pd_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;
    localparam logic [WORD_W-1:0] NIB_SEL = 32'h0FF0_0FF0;

    typedef enum logic [2:0] {
        BPP1  = 3'd0,
        BPP2  = 3'd1,
        BPP4  = 3'd2,
        BPP8  = 3'd3,
        BPP16 = 3'd4,
        BPP32 = 3'd5
    } depth_e;

    typedef struct packed {
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } word_pair_t;

    function automatic depth_e decode_depth(input logic [2:0] code);
        case (code)
            3'd0:    return BPP1;
            3'd1:    return BPP2;
            3'd2:    return BPP4;
            3'd3:    return BPP8;
            3'd4:    return BPP16;
            default: return BPP32;
        endcase
    endfunction

    // lanes 1,1,0,0 of a halfword
    function automatic logic [WORD_W-1:0] byte_pairs(input logic [HALF_W-1:0] h);
        return {h[15:8], h[15:8], h[7:0], h[7:0]};
    endfunction

    // nibble repeat: masked slots take the lane-repeated word moved up one nibble
    function automatic logic [WORD_W-1:0] nibble_pairs(input logic [HALF_W-1:0] h);
        logic [WORD_W-1:0] rep;
        rep = byte_pairs(h);
        return (rep & ~NIB_SEL) | ((rep << 4) & NIB_SEL);
    endfunction

    function automatic logic [15:0] spread8(input logic [7:0] g);
        logic [15:0] r;
        for (int k = 0; k < 8; k++) begin
            r[2*k]   = g[k];
            r[2*k+1] = g[k];
        end
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] spread16(input logic [HALF_W-1:0] g);
        logic [WORD_W-1:0] r;
        for (int k = 0; k < HALF_W; k++) begin
            r[2*k]   = g[k];
            r[2*k+1] = g[k];
        end
        return r;
    endfunction

    // 2-bit pixels: split into bit planes, widen each plane, weave back
    function automatic logic [WORD_W-1:0] crumb_pairs(input logic [HALF_W-1:0] h);
        logic [7:0]        ev;
        logic [7:0]        od;
        logic [15:0]       ev_w;
        logic [15:0]       od_w;
        logic [WORD_W-1:0] r;
        for (int k = 0; k < 8; k++) begin
            ev[k] = h[2*k];
            od[k] = h[2*k+1];
        end
        ev_w = spread8(ev);
        od_w = spread8(od);
        for (int k = 0; k < 16; k++) begin
            r[2*k]   = ev_w[k];
            r[2*k+1] = od_w[k];
        end
        return r;
    endfunction

endpackage

// File: rtl/pd_ctrl.sv
module pd_ctrl
    import pd_pkg::*;
#(
    parameter int AW = 9,
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [2:0]    depth_code,
    input  logic [CW-1:0] src_words,
    input  logic          run_done,
    output logic          launch,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          cap,
    output logic          cap_last,
    output logic          zero_done,
    output logic          busy,
    output depth_e        depth_q
);

    logic          phase;
    logic [CW-1:0] rd_left;
    logic [AW-1:0] rd_ptr;

    assign launch  = start && !busy;
    assign rd_en   = busy && !phase && (rd_left != '0);
    assign rd_addr = rd_ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            phase     <= 1'b0;
            rd_left   <= '0;
            rd_ptr    <= '0;
            cap       <= 1'b0;
            cap_last  <= 1'b0;
            zero_done <= 1'b0;
            depth_q   <= BPP1;
        end else begin
            zero_done <= 1'b0;
            cap       <= rd_en;
            cap_last  <= rd_en && (rd_left == CW'(1));
            if (launch) begin
                depth_q <= decode_depth(depth_code);
                rd_ptr  <= '0;
                rd_left <= src_words;
                phase   <= 1'b0;
                if (src_words != '0) busy      <= 1'b1;
                else                 zero_done <= 1'b1;
            end else if (busy) begin
                phase <= ~phase;
                if (rd_en) begin
                    rd_ptr  <= rd_ptr + 1'b1;
                    rd_left <= rd_left - 1'b1;
                end
                if (run_done) busy <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pd_expand.sv
module pd_expand
    import pd_pkg::*;
(
    input  depth_e            depth,
    input  logic [WORD_W-1:0] src,
    output word_pair_t        pair
);

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [HALF_W-1:0] part;
        logic [WORD_W-1:0] dbl;
        assign part = src[h*HALF_W +: HALF_W];
        always_comb begin
            case (depth)
                BPP1:    dbl = spread16(part);
                BPP2:    dbl = crumb_pairs(part);
                BPP4:    dbl = nibble_pairs(part);
                BPP8:    dbl = byte_pairs(part);
                BPP16:   dbl = {part, part};
                default: dbl = src;
            endcase
        end
    end

    assign pair.lo = g_half[0].dbl;
    assign pair.hi = g_half[1].dbl;

endmodule

// File: rtl/pd_emit.sv
module pd_emit
    import pd_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              cap,
    input  logic              cap_last,
    input  word_pair_t        pair,
    output logic              wr_en,
    output logic [AW:0]       wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              run_done
);

    logic [WORD_W-1:0] hold;
    logic              pend;
    logic              hi_phase;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            hold     <= '0;
            pend     <= 1'b0;
            hi_phase <= 1'b0;
            last_q   <= 1'b0;
            run_done <= 1'b0;
        end else begin
            run_done <= wr_en && hi_phase && last_q;
            if (clear)      wr_addr <= '0;
            else if (wr_en) wr_addr <= wr_addr + 1'b1;
            if (cap) begin
                wr_en    <= 1'b1;
                wr_data  <= pair.lo;
                hold     <= pair.hi;
                pend     <= 1'b1;
                hi_phase <= 1'b0;
                last_q   <= cap_last;
            end else if (pend) begin
                wr_en    <= 1'b1;
                wr_data  <= hold;
                pend     <= 1'b0;
                hi_phase <= 1'b1;
            end else begin
                wr_en    <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pixel_doubler.sv
module pixel_doubler
    import pd_pkg::*;
#(
    parameter int MAX_WORDS = 320,
    localparam int AW = $clog2(MAX_WORDS),
    localparam int CW = $clog2(MAX_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        depth,
    input  logic [CW-1:0]     src_words,
    output logic              rd_en,
    output logic [AW-1:0]     rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic              wr_en,
    output logic [AW:0]       wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              done
);

    logic       launch;
    logic       cap;
    logic       cap_last;
    logic       zero_done;
    logic       run_done;
    logic       busy;
    depth_e     depth_q;
    word_pair_t pair;

    pd_ctrl #(.AW(AW), .CW(CW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .depth_code (depth),
        .src_words  (src_words),
        .run_done   (run_done),
        .launch     (launch),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .cap        (cap),
        .cap_last   (cap_last),
        .zero_done  (zero_done),
        .busy       (busy),
        .depth_q    (depth_q)
    );

    pd_expand u_expand (
        .depth (depth_q),
        .src   (rd_data),
        .pair  (pair)
    );

    pd_emit #(.AW(AW)) u_emit (
        .clk      (clk),
        .rst      (rst),
        .clear    (launch),
        .cap      (cap),
        .cap_last (cap_last),
        .pair     (pair),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .run_done (run_done)
    );

    assign done = run_done | zero_done;

endmodule

module pd_doubler_checker #(
    parameter int AW = 9
) (
    input logic        clk,
    input logic        rst,
    input logic        rd_en,
    input logic        wr_en,
    input logic [AW:0] wr_addr,
    input logic [31:0] wr_data,
    input logic        done,
    input logic        busy,
    input logic [2:0]  depth_q
);

    assert_pair_order_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en && !wr_addr[0] |=> wr_en && (wr_addr == $past(wr_addr) + 1'b1));

    assert_read_spacing_R9: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> !rd_en);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_word_repeat_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_addr[0] && (depth_q == 3'd5) |-> wr_data == $past(wr_data));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !rd_en && !wr_en);

endmodule

bind pixel_doubler pd_doubler_checker #(.AW(AW)) u_checker (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .done    (done),
    .busy    (busy),
    .depth_q (depth_q)
);

// File: tb/pixel_doubler_bench.sv
`timescale 1ns/100ps
module pixel_doubler_bench;

    localparam int CW = 9;
    localparam int AW = 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [2:0]    depth = 3'd0;
    logic [CW-1:0] src_words = '0;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [31:0]   rd_data = '0;
    logic          wr_en;
    logic [AW:0]   wr_addr;
    logic [31:0]   wr_data;
    logic          done;

    always #2 clk = ~clk;

    pixel_doubler u_pixel_doubler (
        .clk(clk), .rst(rst), .start(start), .depth(depth), .src_words(src_words),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
    );

    logic [31:0] src_mem [512];
    logic [31:0] dst_mem [1024];

    always @(posedge clk) if (rd_en) rd_data <= src_mem[rd_addr];

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int wr_cnt, rd_cnt, done_cnt, order_err, rd_err, done_cyc, t0;
    logic rd_prev = 1'b0;
    int n_chk = 0;
    int n_fail = 0;

    always @(negedge clk) begin
        if (wr_en) begin
            dst_mem[wr_addr] = wr_data;
            if (int'(wr_addr) != wr_cnt) order_err++;
            wr_cnt++;
        end
        if (rd_en) begin
            if (int'(rd_addr) != rd_cnt) rd_err++;
            if (rd_prev) rd_err++;
            rd_cnt++;
        end
        rd_prev = rd_en;
        if (done) begin
            done_cnt++;
            done_cyc = cyc;
        end
    end

    // stimulus and expected results: {code, source, first word, second word}
    localparam logic [98:0] VEC [12] = '{
        {3'd3, 32'h1234_5678, 32'h5656_7878, 32'h1212_3434},
        {3'd4, 32'h1234_5678, 32'h5678_5678, 32'h1234_1234},
        {3'd5, 32'h1234_5678, 32'h1234_5678, 32'h1234_5678},
        {3'd2, 32'h1234_5678, 32'h5566_7788, 32'h1122_3344},
        {3'd0, 32'h8001_00A5, 32'h0000_CC33, 32'hC000_0003},
        {3'd1, 32'hC000_00E4, 32'h0000_FA50, 32'hF000_0000},
        {3'd2, 32'hFEDC_BA98, 32'hBBAA_9988, 32'hFFEE_DDCC},
        {3'd3, 32'hFF00_AA55, 32'hAAAA_5555, 32'hFFFF_0000},
        {3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {3'd1, 32'h5555_AAAA, 32'hAAAA_AAAA, 32'h5555_5555},
        {3'd6, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
        {3'd7, 32'h0F0F_3C3C, 32'h0F0F_3C3C, 32'h0F0F_3C3C}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    function automatic string tag_of(input logic [2:0] code);
        case (code)
            3'd0:    return "R7";
            3'd1:    return "R6";
            3'd2:    return "R5";
            3'd3:    return "R3";
            3'd4:    return "R4";
            default: return "R8";
        endcase
    endfunction

    // independent model: output pixel m repeats input pixel m/2 of the chosen half
    function automatic logic [31:0] ref_half(input logic [2:0] code, input logic [31:0] w, input int hsel);
        int b;
        logic [31:0] r;
        case (code)
            3'd0: b = 1;
            3'd1: b = 2;
            3'd2: b = 4;
            3'd3: b = 8;
            3'd4: b = 16;
            default: b = 32;
        endcase
        if (b == 32) return w;
        for (int j = 0; j < 32; j++) r[j] = w[hsel*16 + ((j / b) / 2) * b + (j % b)];
        return r;
    endfunction

    task automatic run_job(input logic [2:0] code, input int n, input int poke_at);
        int guard;
        wr_cnt = 0; rd_cnt = 0; done_cnt = 0; order_err = 0; rd_err = 0; done_cyc = -1;
        @(negedge clk); #1;
        start = 1'b1; depth = code; src_words = CW'(n); t0 = cyc;
        @(negedge clk); #1;
        start = 1'b0; depth = code ^ 3'd1; src_words = CW'(2);
        guard = 0;
        while (done_cnt == 0 && guard < 2000) begin
            @(negedge clk); #1;
            guard++;
            if (guard == poke_at) begin
                start = 1'b1; depth = 3'd0; src_words = CW'(3);
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        repeat (4) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        report();
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) src_mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        #1;
        // R1: quiet while in reset
        chk(!rd_en && !wr_en && !done, "R1 in reset", {29'b0, rd_en, wr_en, done}, 32'h0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(!rd_en && !wr_en && !done, "R1 after reset", {29'b0, rd_en, wr_en, done}, 32'h0);

        // vector table: one word per run, each depth
        for (int i = 0; i < 12; i++) begin
            logic [2:0] code;
            code = VEC[i][98:96];
            src_mem[0] = VEC[i][95:64];
            run_job(code, 1, 0);
            chk(dst_mem[0] === VEC[i][63:32], tag_of(code), dst_mem[0], VEC[i][63:32]);
            chk(dst_mem[1] === VEC[i][31:0], tag_of(code), dst_mem[1], VEC[i][31:0]);
            chk(wr_cnt == 2 && done_cnt == 1, "R2 one word two writes", wr_cnt, 2);
            chk(done_cyc - t0 == 5, "R9 done timing one word", done_cyc - t0, 5);
        end

        // R2/R9/R5: seven words at 4 bpp, order and timing
        for (int i = 0; i < 7; i++) src_mem[i] = 32'h9E37_79B9 * (i + 1);
        run_job(3'd2, 7, 0);
        chk(wr_cnt == 14 && order_err == 0, "R2 write order", order_err, 0);
        chk(rd_cnt == 7 && rd_err == 0, "R9 read order and spacing", rd_err, 0);
        chk(done_cyc - t0 == 17, "R9 done timing seven words", done_cyc - t0, 17);
        for (int i = 0; i < 7; i++) begin
            chk(dst_mem[2*i] === ref_half(3'd2, src_mem[i], 0), "R5 multi low", dst_mem[2*i], ref_half(3'd2, src_mem[i], 0));
            chk(dst_mem[2*i+1] === ref_half(3'd2, src_mem[i], 1), "R5 multi high", dst_mem[2*i+1], ref_half(3'd2, src_mem[i], 1));
        end

        // R10: start during a run is ignored
        for (int i = 0; i < 6; i++) src_mem[i] = 32'hA5C3_0F96 ^ (32'h0101_0101 * i);
        run_job(3'd3, 6, 3);
        chk(wr_cnt == 12 && done_cnt == 1, "R10 no restart", wr_cnt, 12);
        chk(done_cyc - t0 == 15, "R10 timing kept", done_cyc - t0, 15);
        for (int i = 0; i < 6; i++)
            chk(dst_mem[2*i] === ref_half(3'd3, src_mem[i], 0), "R10 depth held", dst_mem[2*i], ref_half(3'd3, src_mem[i], 0));

        // R11: empty line
        run_job(3'd3, 0, 0);
        chk(wr_cnt == 0 && rd_cnt == 0, "R11 no traffic", wr_cnt + rd_cnt, 0);
        chk(done_cnt == 1 && done_cyc - t0 == 1, "R11 done next cycle", done_cyc - t0, 1);

        // R12: full 320-pixel line at 8 bpp
        for (int i = 0; i < 80; i++) src_mem[i] = {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)};
        run_job(3'd3, 80, 0);
        chk(wr_cnt == 160 && order_err == 0, "R12 write count", wr_cnt, 160);
        chk(done_cyc - t0 == 163, "R12 done timing", done_cyc - t0, 163);
        chk(dst_mem[159] === ref_half(3'd3, src_mem[79], 1), "R12 last word", dst_mem[159], ref_half(3'd3, src_mem[79], 1));
        chk(dst_mem[0] === 32'h0101_0000, "R12 first word", dst_mem[0], 32'h0101_0000);

        report();
        $finish;
    end

endmodule